// File: doc/BRIEF.md
# Parallel Result Readout Port

This block is the host-facing readout side of a six-channel sampling converter. It keeps six conversion results in an output register bank, which the converter side fills in one cycle through a wide parallel load port. A host reads the results over a 16-bit parallel data bus, using an active-low chip select and an active-low read strobe. The bus lanes are driven only while both strobes are low. At all other times the lane enables are deasserted, so the pad ring can float the lines.

A mode input selects the transfer width. Word transfers move a whole result in one access. Byte transfers put each result on the upper eight lines in two accesses, and a byte-order input chooses which half comes first. The block steps through the channel results in the order A0, A1, B0, B1, C0, C1, one step per completed result. When the last channel has been read it returns to the first and raises a one-clock read-done pulse. Both strobes come from an asynchronous host, so each passes through a synchroniser before any decision is made on it.

Top module: `rro_readout_top`

## Requirements
- R1: Each lane-enable bit of `db_oe_o` (bit 1 for lines 15:8, bit 0 for lines 7:0) is 0 unless both synchronised strobes are low. While the enables are 0, `db_o` reads as zero. This includes the state just after reset.
- R2: In word mode (`byte_mode_i` = 0), a selected access drives `db_oe_o` = 2'b11 and presents the full 16-bit result of the current channel on `db_o`.
- R3: In byte mode (`byte_mode_i` = 1), a selected access drives `db_oe_o` = 2'b10 only. One byte appears on `db_o[15:8]`, `db_o[7:0]` stays zero, and a result takes two accesses.
- R4: In byte mode with `lo_first_i` = 0, the first access of a result carries bits 15:8 and the second carries bits 7:0. With `lo_first_i` = 1, the order is reversed.
- R5: Channel index k (0..5, meaning A0, A1, B0, B1, C0, C1) is held in `load_data_i[16k+15:16k]`. The current channel advances by one on the synchronised rising edge of the read strobe that ends a complete result: every access in word mode, the second access in byte mode.
- R6: After channel 5 has been read, the current channel returns to 0, and `read_done_o` is high for exactly one clock. It rises on the third clock edge after the read strobe rises. A read that does not wrap gives no pulse.
- R7: A load cycle (`load_i` = 1) stores the new results and restarts the readout at channel 0 and the first byte. This holds even in the middle of a sequence.
- R8: A read-strobe pulse while chip select is high drives no lane and does not move the channel or the byte phase.
- R9: Each strobe passes a two-stage synchroniser. The lanes are enabled from the second clock edge after both strobes go low, and not at the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Host chip select, active low, asynchronous |
| rd_n_i | input | 1 | Host read strobe, active low, asynchronous |
| byte_mode_i | input | 1 | 0: 16-bit word transfers; 1: two byte transfers on lines 15:8 |
| lo_first_i | input | 1 | Byte mode order: 0 high byte first, 1 low byte first |
| load_i | input | 1 | Load strobe for a new result set |
| load_data_i | input | 96 | Six results, channel k in bits 16k+15:16k |
| db_o | output | 16 | Read data bus value |
| db_oe_o | output | 2 | Lane drive enables: bit 1 lines 15:8, bit 0 lines 7:0 |
| read_done_o | output | 1 | One-clock pulse after the last channel has been read |

## Verification
A wrong channel pointer shows at the ports on the next selected access: the data is the result of a neighbouring channel, and the read-done pulse arrives one read early or late within the same sweep. A stuck or inverted byte phase shows at once as swapped or repeated bytes on the upper lines. A faulty synchroniser or edge detector shows as lanes that enable one cycle early, or as a read that never advances. The bench tracks the expected channel and phase itself and compares every access, so each of these errors is caught on the first access it corrupts.

// File: rtl/rro_pkg.sv
package rro_pkg;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } rro_phase_e;

    typedef enum logic [1:0] {
        LANES_NONE  = 2'b00,
        LANES_UPPER = 2'b10,
        LANES_ALL   = 2'b11
    } rro_lanes_e;

endpackage

// File: rtl/rro_sync.sv
module rro_sync #(
    parameter int               WIDTH     = 2,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rro_result_bank.sv
module rro_result_bank #(
    parameter int DATA_W = 16,
    parameter int NUM_CH = 6,
    parameter int PTR_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [NUM_CH*DATA_W-1:0] load_data_i,
    input  logic [PTR_W-1:0]         sel_i,
    output logic [DATA_W-1:0]        word_o
);

    logic [NUM_CH-1:0][DATA_W-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (load_i) begin
            bank_d = load_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        word_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel_i == PTR_W'(i)) begin
                word_o = bank_q[i];
            end
        end
    end

endmodule

// File: rtl/rro_read_ctrl.sv
module rro_read_ctrl
    import rro_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int PTR_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_s_i,
    input  logic             rd_s_i,
    input  logic             byte_mode_i,
    input  logic             load_i,
    output logic [PTR_W-1:0] ptr_o,
    output rro_phase_e       phase_o,
    output logic             drive_o,
    output logic             done_o
);

    localparam logic [PTR_W-1:0] LAST_CH = PTR_W'(NUM_CH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        rro_phase_e       phase;
        logic             rd_p;
        logic             en_p;
        logic             done;
    } ctrl_state_t;

    ctrl_state_t state_d, state_q;
    logic        drive;
    logic        complete;

    always_comb begin
        drive    = !cs_s_i && !rd_s_i;
        complete = rd_s_i && !state_q.rd_p && state_q.en_p;

        state_d      = state_q;
        state_d.rd_p = rd_s_i;
        state_d.en_p = drive;
        state_d.done = 1'b0;

        if (load_i) begin
            state_d.ptr   = '0;
            state_d.phase = PH_FIRST;
        end else if (complete) begin
            if (byte_mode_i && state_q.phase == PH_FIRST) begin
                state_d.phase = PH_SECOND;
            end else begin
                state_d.phase = PH_FIRST;
                if (state_q.ptr == LAST_CH) begin
                    state_d.ptr  = '0;
                    state_d.done = 1'b1;
                end else begin
                    state_d.ptr = state_q.ptr + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{ptr: '0, phase: PH_FIRST, rd_p: 1'b1, en_p: 1'b0, done: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign ptr_o   = state_q.ptr;
    assign phase_o = state_q.phase;
    assign drive_o = drive;
    assign done_o  = state_q.done;

endmodule

// File: rtl/rro_lane_mux.sv
module rro_lane_mux
    import rro_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              drive_i,
    input  logic              byte_mode_i,
    input  logic              lo_first_i,
    input  rro_phase_e        phase_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] db_o,
    output logic [1:0]        db_oe_o
);

    localparam int HALF_W = DATA_W / 2;

    logic take_low;

    always_comb begin
        take_low = lo_first_i ^ (phase_i == PH_SECOND);
        db_o     = '0;
        db_oe_o  = LANES_NONE;
        if (drive_i) begin
            if (byte_mode_i) begin
                db_oe_o = LANES_UPPER;
                db_o[DATA_W-1:HALF_W] = take_low ? word_i[HALF_W-1:0]
                                                 : word_i[DATA_W-1:HALF_W];
            end else begin
                db_oe_o = LANES_ALL;
                db_o    = word_i;
            end
        end
    end

endmodule

// File: rtl/rro_readout_top.sv
module rro_readout_top
    import rro_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int NUM_CH      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n_i,
    input  logic                     rd_n_i,
    input  logic                     byte_mode_i,
    input  logic                     lo_first_i,
    input  logic                     load_i,
    input  logic [NUM_CH*DATA_W-1:0] load_data_i,
    output logic [DATA_W-1:0]        db_o,
    output logic [1:0]               db_oe_o,
    output logic                     read_done_o
);

    localparam int PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [1:0]        strobe_s;
    logic [PTR_W-1:0]  ptr;
    rro_phase_e        phase;
    logic              drive;
    logic [DATA_W-1:0] cur_word;

    rro_sync #(
        .WIDTH    (2),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(2'b11)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({cs_n_i, rd_n_i}),
        .q_o  (strobe_s)
    );

    rro_read_ctrl #(
        .NUM_CH(NUM_CH),
        .PTR_W (PTR_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_s_i     (strobe_s[1]),
        .rd_s_i     (strobe_s[0]),
        .byte_mode_i(byte_mode_i),
        .load_i     (load_i),
        .ptr_o      (ptr),
        .phase_o    (phase),
        .drive_o    (drive),
        .done_o     (read_done_o)
    );

    rro_result_bank #(
        .DATA_W(DATA_W),
        .NUM_CH(NUM_CH),
        .PTR_W (PTR_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .load_data_i(load_data_i),
        .sel_i      (ptr),
        .word_o     (cur_word)
    );

    rro_lane_mux #(
        .DATA_W(DATA_W)
    ) u_mux (
        .drive_i    (drive),
        .byte_mode_i(byte_mode_i),
        .lo_first_i (lo_first_i),
        .phase_i    (phase),
        .word_i     (cur_word),
        .db_o       (db_o),
        .db_oe_o    (db_oe_o)
    );

endmodule

// File: rtl/rro_checker.sv
module rro_checker #(
    parameter int DATA_W      = 16,
    parameter int NUM_CH      = 6,
    parameter int PTR_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_i,
    input logic              rd_n_i,
    input logic              byte_mode_i,
    input logic              load_i,
    input logic [DATA_W-1:0] db_o,
    input logic [1:0]        db_oe_o,
    input logic              read_done_o,
    input logic [PTR_W-1:0]  ptr,
    input logic              phase
);

    localparam int HALF_W = DATA_W / 2;

    generate
        if (SYNC_STAGES == 2) begin : g_two_stage
            // R1, R9
            a_r1_quiet_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
                $past(cs_n_i, 2) |-> (db_oe_o == 2'b00 && db_o == '0));
            a_r9_quiet_rd_high: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rd_n_i, 2) |-> (db_oe_o == 2'b00));
        end
    endgenerate

    a_r2_word_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_mode_i && db_oe_o != 2'b00) |-> (db_oe_o == 2'b11));

    a_r3_byte_upper_only: assert property (@(posedge clk) disable iff (!rst_n)
        byte_mode_i |-> (db_oe_o[0] == 1'b0 && db_o[HALF_W-1:0] == '0));

    a_r5_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ptr < PTR_W'(NUM_CH));

    a_r5_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) |-> (ptr == '0 || {1'b0, ptr} == {1'b0, $past(ptr)} + 1'b1));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        read_done_o |=> !read_done_o);

    a_r6_done_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        read_done_o |-> (ptr == '0 && phase == 1'b0));

    a_r7_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_i) |-> (ptr == '0 && phase == 1'b0 && !read_done_o));

endmodule

bind rro_readout_top rro_checker #(
    .DATA_W     (DATA_W),
    .NUM_CH     (NUM_CH),
    .PTR_W      (PTR_W),
    .SYNC_STAGES(SYNC_STAGES)
) i_rro_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_i     (cs_n_i),
    .rd_n_i     (rd_n_i),
    .byte_mode_i(byte_mode_i),
    .load_i     (load_i),
    .db_o       (db_o),
    .db_oe_o    (db_oe_o),
    .read_done_o(read_done_o),
    .ptr        (ptr),
    .phase      (phase)
);

// File: tb/test_rro_readout_top.sv
`timescale 1ns/1ps
module test_rro_readout_top;

    localparam int DATA_W = 16;
    localparam int NUM_CH = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic rd_n = 1'b1;
    logic byte_mode = 1'b0;
    logic lo_first = 1'b0;
    logic load = 1'b0;
    logic [NUM_CH*DATA_W-1:0] load_data = '0;
    logic [DATA_W-1:0] db;
    logic [1:0] db_oe;
    logic read_done;

    always #2.5 clk = ~clk;

    rro_readout_top i_rro_readout_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (cs_n),
        .rd_n_i     (rd_n),
        .byte_mode_i(byte_mode),
        .lo_first_i (lo_first),
        .load_i     (load),
        .load_data_i(load_data),
        .db_o       (db),
        .db_oe_o    (db_oe),
        .read_done_o(read_done)
    );

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [15:0] data;
        logic [1:0]  oe;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    logic [DATA_W-1:0] model_res [NUM_CH];
    int m_ptr = 0;
    bit m_phase = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        exp_t e;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            check(e.tag, {14'd0, db_oe, db}, {14'd0, e.oe, e.data});
        end
    end

    function automatic bit model_advance();
        bit wrap = 1'b0;
        if (byte_mode && !m_phase) begin
            m_phase = 1'b1;
        end else begin
            m_phase = 1'b0;
            if (m_ptr == NUM_CH - 1) begin
                m_ptr = 0;
                wrap = 1'b1;
            end else begin
                m_ptr++;
            end
        end
        return wrap;
    endfunction

    function automatic exp_t expect_selected(input string tag);
        exp_t e;
        logic [15:0] w = model_res[m_ptr];
        e.tag = tag;
        if (!byte_mode) begin
            e.data = w;
            e.oe   = 2'b11;
        end else begin
            e.oe   = 2'b10;
            e.data = {((lo_first ^ m_phase) ? w[7:0] : w[15:8]), 8'h00};
        end
        return e;
    endfunction

    task automatic load_set(input int seed);
        @(negedge clk);
        for (int i = 0; i < NUM_CH; i++) begin
            logic [15:0] r;
            r = 16'(seed * 16'h9E37 + i * 16'h1357) ^ 16'(i << 12);
            load_data[i*DATA_W +: DATA_W] = r;
            model_res[i] = r;
        end
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        m_ptr = 0;
        m_phase = 1'b0;
    endtask

    task automatic access(input bit sel, input bit cs_with_rd, input string tag);
        exp_t e;
        bit wrap = 1'b0;
        int cnt = 0;
        @(negedge clk);
        cs_n = !sel;
        rd_n = 1'b0;
        repeat (2) @(posedge clk);
        if (sel) begin
            e = expect_selected(tag);
        end else begin
            e.tag = tag;
            e.data = '0;
            e.oe = 2'b00;
        end
        sb_q.push_back(e);
        @(negedge clk);
        rd_n = 1'b1;
        if (cs_with_rd) cs_n = 1'b1;
        if (sel) wrap = model_advance();
        repeat (5) begin
            @(negedge clk);
            if (read_done) cnt++;
        end
        check({tag, " R6 done count"}, cnt, wrap ? 1 : 0);
        cs_n = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset oe", {30'd0, db_oe}, 0);
        check("R1 reset data", {16'd0, db}, 0);
        check("R6 reset done", {31'd0, read_done}, 0);

        load_set(1);

        // R1 cs low, rd high: no drive
        @(negedge clk);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 cs only oe", {30'd0, db_oe}, 0);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);

        // R9 latency, word mode channel 0 (R2)
        cs_n = 1'b0;
        rd_n = 1'b0;
        @(negedge clk);
        check("R9 one edge oe", {30'd0, db_oe}, 0);
        @(negedge clk);
        check("R9 two edges oe", {30'd0, db_oe}, 2'b11);
        check("R2 word ch0", {16'd0, db}, {16'd0, model_res[0]});
        rd_n = 1'b1;
        void'(model_advance());
        repeat (4) @(negedge clk);
        cs_n = 1'b1;

        // R2/R5/R6 word sweep
        for (int i = 1; i < NUM_CH; i++) access(1'b1, 1'b0, $sformatf("R2 R5 word ch%0d", i));
        for (int i = 0; i < NUM_CH; i++) access(1'b1, 1'b1, $sformatf("R5 word cs-with-rd ch%0d", i));

        // R8 ignored reads
        access(1'b0, 1'b0, "R8 deselected read 1");
        access(1'b0, 1'b0, "R8 deselected read 2");
        access(1'b1, 1'b0, "R8 next read ch0");

        // R3/R4 byte mode high first
        load_set(7);
        byte_mode = 1'b1;
        lo_first = 1'b0;
        for (int i = 0; i < 2*NUM_CH; i++) access(1'b1, 1'b0, $sformatf("R3 R4 hi-first acc%0d", i));

        // R4 low first
        lo_first = 1'b1;
        for (int i = 0; i < 2*NUM_CH; i++) access(1'b1, 1'b1, $sformatf("R4 lo-first acc%0d", i));

        // R8 in byte mode mid-result
        access(1'b1, 1'b0, "R3 first half");
        access(1'b0, 1'b0, "R8 deselected in byte mode");
        access(1'b1, 1'b0, "R8 second half kept");

        // R7 load mid sequence
        load_set(2);
        byte_mode = 1'b0;
        access(1'b1, 1'b0, "R7 word ch0");
        access(1'b1, 1'b0, "R7 word ch1");
        byte_mode = 1'b1;
        access(1'b1, 1'b0, "R7 byte first half");
        load_set(3);
        access(1'b1, 1'b0, "R7 restart first byte");
        access(1'b1, 1'b0, "R7 restart second byte");

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule